// File: doc/BRIEF.md
# Streaming Line Doubler with Linear Interpolation

This block doubles the horizontal sample count of a video line. Pixels arrive one per beat on a valid/ready stream, each pixel carrying three independent colour components and a flag that marks the last pixel of the line. For every input pixel the block emits two output beats. The first beat is the pixel itself. The second beat is the mean of that pixel and the one that follows it in the line. A line of 640 pixels therefore leaves as 1280 pixels.

The last pixel of a line has no successor, so its second beat simply repeats it. That repeat carries the output end-of-line flag. Each output component is one bit wider than its input, and that extra low bit is worth one half. Means that fall halfway between two integer values are therefore carried exactly: inputs 1 and 10 leave as 11, which reads as 5.5. An original sample v leaves as v shifted left by one.

The block keeps one pixel in hand so that it can form the mean when the next pixel arrives. Backpressure on the output stalls the input side.

Top module: `line_doubler`

## Requirements
- R1: The first output beat for a pixel that opens a line is that pixel, each component widened as {v, 1'b0}.
- R2: When a pixel arrives while an earlier pixel of the same line is held, the next output beat is, per component, the zero-extended sum held + new (the mean with one half-weight LSB). The beat after it is the new pixel widened as in R1.
- R3: The second beat of the last pixel of a line carries the same value as the beat just before it on all components.
- R4: out_eol is high only on the final beat of a line. Once that beat is taken, out_valid is low in the next cycle.
- R5: Each colour component is computed only from the same component of the input pixels.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_r, out_g, out_b and out_eol hold their values in the next cycle.
- R7: A line of N pixels yields exactly 2N output beats, in order, whatever pattern out_ready follows.
- R8: Synchronous reset leaves out_valid low and in_ready high, and discards any held pixel. A line that starts after reset is unaffected by pixels accepted before it.
- R9: Once the end-of-line pixel is accepted, the block produces both of its beats without any further input. The first of them is offered in the cycle after acceptance.
- R10: A line of a single pixel yields two identical beats, the second with out_eol high.
- R11: in_ready is low in every cycle in which out_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel |
| in_r | input | PIX_W | Red component in |
| in_g | input | PIX_W | Green component in |
| in_b | input | PIX_W | Blue component in |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_r | output | PIX_W+1 | Red out, LSB weighs one half |
| out_g | output | PIX_W+1 | Green out, LSB weighs one half |
| out_b | output | PIX_W+1 | Blue out, LSB weighs one half |
| out_eol | output | 1 | Final beat of the line |

## Verification
The hardest case to reach from the ports is a reset that lands while a pixel is held in the middle of a line. A later line would then blend with a stale sample. To reach it, the stimulus sends two pixels without an end-of-line flag, lets only part of the output drain, and then pulses reset. It then sends a one-pixel line and expects exactly that pixel twice. The second hard case is a stall that lands on the duplicated end-of-line beat. A pseudo-random ready pattern held over a 640-pixel line and a shorter gapped line brings stalls onto every kind of beat, including that one.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  localparam int LDB_CHANNELS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ORIG,
    ST_WAIT,
    ST_MEAN,
    ST_DUP
  } ldb_state_e;
endpackage

// File: rtl/ldb_lane.sv
module ldb_lane #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_held,
  input  logic             load_mean,
  input  logic             sel_mean,
  input  logic [PIX_W-1:0] in_d,
  output logic [PIX_W:0]   out_d
);
  // widen an original sample into the half-LSB output format
  function automatic logic [PIX_W:0] as_fixed(input logic [PIX_W-1:0] v);
    return {v, 1'b0};
  endfunction

  // a + b equals twice the mean, which is the mean in half-LSB format
  function automatic logic [PIX_W:0] pair_sum(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [PIX_W-1:0] held_q;
  logic [PIX_W:0]   mean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      mean_q <= '0;
    end else begin
      if (load_mean) mean_q <= pair_sum(held_q, in_d);
      if (load_held) held_q <= in_d;
    end
  end

  assign out_d = sel_mean ? mean_q : as_fixed(held_q);
endmodule

// File: rtl/ldb_ctrl.sv
module ldb_ctrl
  import ldb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take_in,
  input  logic take_out,
  input  logic in_eol,
  output logic in_ready,
  output logic out_valid,
  output logic out_eol,
  output logic load_held,
  output logic load_mean,
  output logic sel_mean
);
  ldb_state_e state_q;
  logic       held_eol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      held_eol_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_in) begin
          state_q    <= ST_ORIG;
          held_eol_q <= in_eol;
        end
        ST_ORIG: if (take_out) state_q <= held_eol_q ? ST_DUP : ST_WAIT;
        ST_WAIT: if (take_in) begin
          state_q    <= ST_MEAN;
          held_eol_q <= in_eol;
        end
        ST_MEAN: if (take_out) state_q <= ST_ORIG;
        ST_DUP:  if (take_out) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
    out_valid = (state_q == ST_ORIG) || (state_q == ST_MEAN) || (state_q == ST_DUP);
    out_eol   = (state_q == ST_DUP);
    sel_mean  = (state_q == ST_MEAN);
    load_held = take_in;
    load_mean = take_in && (state_q == ST_WAIT);
  end
endmodule

// File: rtl/line_doubler.sv
module line_doubler
  import ldb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W:0]   out_r,
  output logic [PIX_W:0]   out_g,
  output logic [PIX_W:0]   out_b,
  output logic             out_eol
);
  localparam int OUT_W = PIX_W + 1;

  logic acc_in;
  logic acc_out;
  logic load_held, load_mean, sel_mean;

  logic [PIX_W-1:0] lane_in  [LDB_CHANNELS];
  logic [OUT_W-1:0] lane_out [LDB_CHANNELS];

  assign acc_in  = in_valid && in_ready;
  assign acc_out = out_valid && out_ready;

  assign lane_in[0] = in_r;
  assign lane_in[1] = in_g;
  assign lane_in[2] = in_b;
  assign out_r = lane_out[0];
  assign out_g = lane_out[1];
  assign out_b = lane_out[2];

  ldb_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .take_in   (acc_in),
    .take_out  (acc_out),
    .in_eol    (in_eol),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_eol   (out_eol),
    .load_held (load_held),
    .load_mean (load_mean),
    .sel_mean  (sel_mean)
  );

  for (genvar c = 0; c < LDB_CHANNELS; c++) begin : g_lane
    ldb_lane #(.PIX_W(PIX_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .load_held (load_held),
      .load_mean (load_mean),
      .sel_mean  (sel_mean),
      .in_d      (lane_in[c]),
      .out_d     (lane_out[c])
    );
  end
endmodule

// File: rtl/ldb_checker.sv
module ldb_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eol,
  input logic [PIX_W-1:0] in_r,
  input logic [PIX_W-1:0] in_g,
  input logic [PIX_W-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_eol,
  input logic [PIX_W:0]   out_r,
  input logic [PIX_W:0]   out_g,
  input logic [PIX_W:0]   out_b,
  input logic             acc_in,
  input logic             acc_out
);
  localparam int OUT_ALL = 3 * (PIX_W + 1);

  logic                 line_open;
  logic [PIX_W-1:0]     prev_r, prev_g, prev_b;
  logic [OUT_ALL-1:0]   last_out;
  logic                 last_seen;
  logic [OUT_ALL-1:0]   out_all;

  assign out_all = {out_r, out_g, out_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      line_open <= 1'b0;
      prev_r    <= '0;
      prev_g    <= '0;
      prev_b    <= '0;
      last_out  <= '0;
      last_seen <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        line_open <= !in_eol;
        prev_r    <= in_r;
        prev_g    <= in_g;
        prev_b    <= in_b;
      end
      if (out_valid && out_ready) begin
        last_out  <= out_all;
        last_seen <= 1'b1;
      end
    end
  end

  assert_line_start_R1: assert property (@(posedge clk) disable iff (rst)
    acc_in && !line_open |=> out_valid &&
      out_r == {$past(in_r), 1'b0} && out_g == {$past(in_g), 1'b0} &&
      out_b == {$past(in_b), 1'b0});

  assert_mean_beat_R2: assert property (@(posedge clk) disable iff (rst)
    acc_in && line_open |=> out_valid &&
      out_r == ({1'b0, $past(prev_r)} + {1'b0, $past(in_r)}) &&
      out_g == ({1'b0, $past(prev_g)} + {1'b0, $past(in_g)}) &&
      out_b == ({1'b0, $past(prev_b)} + {1'b0, $past(in_b)}));

  assert_tail_repeat_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eol |-> last_seen && out_all == last_out);

  assert_eol_closes_R4: assert property (@(posedge clk) disable iff (rst)
    acc_out && out_eol |=> !out_valid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_all) && $stable(out_eol));

  assert_eol_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    acc_in && in_eol |=> out_valid && !out_eol);

  assert_in_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);
endmodule

bind line_doubler ldb_checker #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eol    (in_eol),
  .in_r      (in_r),
  .in_g      (in_g),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_eol   (out_eol),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .acc_in    (acc_in),
  .acc_out   (acc_out)
);

// File: tb/sim_line_doubler.sv
`timescale 1ns/1ps
module sim_line_doubler;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready, out_valid, out_eol;
  logic [W:0] out_r, out_g, out_b;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [23:0] px [0:639];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  line_doubler #(.PIX_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_eol(out_eol));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected value in half-LSB format, computed from the requirements
  function automatic logic [26:0] expect_beat(input int idx, input int n);
    logic [26:0] r;
    int i = idx / 2;
    for (int c = 0; c < 3; c++) begin
      logic [8:0] v;
      if ((idx % 2) == 0 || i == n - 1) v = {px[i][c*8 +: 8], 1'b0};
      else v = 9'(px[i][c*8 +: 8]) + 9'(px[i+1][c*8 +: 8]);
      r[c*9 +: 9] = v;
    end
    return r;
  endfunction

  task automatic drive_line(input int n, input int gap, input bit with_eol);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      {in_r, in_g, in_b} = px[i];
      in_eol = with_eol && (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eol = 1'b0;
  endtask

  task automatic collect(input int n, input string req, input bit random_ready, input int idle_lim);
    int beats = 0, idle = 0;
    bit stalled = 0;
    logic [26:0] prev_all = '0;
    logic prev_eol = 0;
    while (beats < 2 * n && idle < idle_lim) begin
      @(negedge clk);
      if (stalled)
        chk(out_valid && {out_r, out_g, out_b} == prev_all && out_eol == prev_eol,
            "R6 stalled beat held", {out_r, out_g, out_b}, prev_all);
      if (random_ready) begin
        out_ready = lfsr[0] | lfsr[3];
        lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      end else out_ready = 1'b1;
      if (out_valid && out_ready) begin
        chk({out_r, out_g, out_b} == expect_beat(beats, n), req,
            {out_r, out_g, out_b}, expect_beat(beats, n));
        chk(out_eol == (beats == 2 * n - 1), {req, " R4 eol flag"}, out_eol, beats == 2 * n - 1);
        beats++;
        idle = 0;
      end else idle++;
      stalled = out_valid && !out_ready;
      prev_all = {out_r, out_g, out_b};
      prev_eol = out_eol;
    end
    chk(beats == 2 * n, {req, " R7 beat count"}, beats, 2 * n);
    @(negedge clk);
    chk(!out_valid, "R4 nothing after line end", out_valid, 0);
  endtask

  task automatic run_line(input int n, input string req, input bit rr, input int gap, input int idle_lim);
    fork
      drive_line(n, gap, 1'b1);
      collect(n, req, rr, idle_lim);
    join
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R8 out_valid after reset", out_valid, 0);
    chk(in_ready, "R8 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_example();
    px[0] = {8'd1, 8'd200, 8'd0};
    px[1] = {8'd10, 8'd7, 8'd1};
    px[2] = {8'd5, 8'd255, 8'd2};
    px[3] = {8'd3, 8'd0, 8'd3};
    run_line(4, "R1/R2/R3 four-pixel line", 1'b0, 0, 50);
  endtask

  task automatic t_single();
    px[0] = {8'd77, 8'd13, 8'd250};
    run_line(1, "R10 single-pixel line", 1'b0, 0, 50);
  endtask

  task automatic t_extremes();
    px[0] = {8'd255, 8'd0, 8'd255};
    px[1] = {8'd255, 8'd255, 8'd0};
    px[2] = {8'd0, 8'd255, 8'd1};
    px[3] = {8'd255, 8'd0, 8'd254};
    run_line(4, "R2 extreme sums", 1'b0, 0, 50);
  endtask

  task automatic t_channels();
    for (int i = 0; i < 12; i++) px[i] = {8'(i * 21), 8'(255 - i * 3), 8'd128};
    run_line(12, "R5 independent channels", 1'b0, 1, 50);
  endtask

  task automatic t_eol_no_wait();
    px[0] = {8'd9, 8'd8, 8'd7};
    px[1] = {8'd100, 8'd50, 8'd25};
    px[2] = {8'd3, 8'd4, 8'd5};
    // idle limit of 4 cycles: the end-of-line pair must come unprompted
    run_line(3, "R9 end pair without more input", 1'b0, 0, 4);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 32; i++) px[i] = {8'(i * 37 + 5), 8'(i * 11), 8'(200 - i)};
    run_line(32, "R6 random stalls", 1'b1, 1, 200);
  endtask

  task automatic t_mid_reset();
    px[0] = {8'd40, 8'd41, 8'd42};
    px[1] = {8'd90, 8'd91, 8'd92};
    @(negedge clk);
    out_ready = 1'b1;
    drive_line(2, 0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R8 mid-line reset out_valid", out_valid, 0);
    chk(in_ready, "R8 mid-line reset in_ready", in_ready, 1);
    px[0] = {8'd2, 8'd4, 8'd6};
    run_line(1, "R8 no stale sample after reset", 1'b0, 0, 50);
  endtask

  task automatic t_full_line();
    for (int i = 0; i < 640; i++) px[i] = {8'(i), 8'(i * 5 + 3), 8'(i ^ 8'h5A)};
    run_line(640, "R7 640-pixel line", 1'b1, 0, 200);
  endtask

  initial begin
    t_reset();
    t_example();
    t_single();
    t_extremes();
    t_channels();
    t_eol_no_wait();
    t_backpressure();
    t_mid_reset();
    t_full_line();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule